// File: doc/BRIEF.md
# Prioritized Local Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt request lines from local-bus devices into a single interrupt output for a processor. Each line is sampled into a source register on every clock, so a source bit is set for exactly as long as its line is held high. A 16-bit enable mask decides which pending sources may raise the combined output.

Software reaches the block over a small byte-addressed, memory-mapped bus. The halfword at offset 0 is read-only and does not return a bitmap. It returns a ready-to-use vector built from the lowest-numbered line that is both pending and enabled. The halfword at offset 2 holds the enable mask. Byte and word accesses are broken down onto these halfwords, so narrow writes merge with the mask's current contents.

Top module: `local_irq_ctrl`

## Requirements
- R1: Each source bit equals its request line as sampled on the previous rising clock edge, so a line that goes low clears its bit.
- R2: `irq_o` is high exactly when at least one source bit and the corresponding mask bit are both set. It reflects a request change one clock after the change is sampled, and a mask write from the clock edge that performs it.
- R3: A read of the halfword at byte offset 0 returns (n+1)*4, where n is the lowest-numbered line that is pending and enabled. It returns 0 when no such line exists. Line 0 has the highest priority.
- R4: The enable mask is a 16-bit read/write halfword at byte offset 2. Mask bits at or above NUM_LINES always read 0.
- R5: `bus_size_i` = 0 selects a byte access. A byte write to offset 2 replaces mask bits 7:0, and a byte write to offset 3 replaces bits 15:8, in both cases from `bus_wdata_i[7:0]`, and the other byte is unchanged. A byte read returns the addressed byte in `bus_rdata_o[7:0]`, with the even address giving the low byte.
- R6: `bus_size_i` = 2 or 3 selects a word access, handled as two halfword accesses: bits 15:0 go to the addressed halfword and bits 31:16 to the halfword 2 bytes above it. A word write at offset 0 therefore loads the mask from `bus_wdata_i[31:16]`. A word read at offset 0 returns the mask in bits 31:16 and the vector in bits 15:0. `bus_size_i` = 1 selects a halfword access in `bus_rdata_o[15:0]` and `bus_wdata_i[15:0]`.
- R7: Writes to offset 0 and to any offset from 4 upward change nothing, and reads from offsets 4 and above return 0.
- R8: While reset is asserted, and after it is released, the mask and the source register are zero, `irq_o` is low and the vector reads 0.
- R9: Lines 0 to 9 are assigned, in priority order, to parallel port, floppy, sound, video, network, SCSI, keyboard, mouse, serial 0 and serial 1. For example, network together with keyboard gives vector 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_LINES | Level-sensitive device request lines |
| bus_sel_i | input | 1 | Access strobe for one cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Write data, low lanes first |
| bus_rdata_o | output | 32 | Combinational read data, 0 when not reading |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The vector path is tried with several inputs:
- a single line on its own, which shows the (n+1)*4 encoding;
- the highest line on its own and then with line 0 added, which shows which end wins;
- pairs of named device lines, which show the fixed assignment;
- a pending line that is masked, which shows that the mask gates both the vector and `irq_o`.

For the mask, halfword, byte and word writes are applied in sequence, so a wrong lane or a lost merge appears as a specific wrong mask value. Writes to the read-only and undefined offsets follow, and the mask read after each one shows whether anything leaked through.

// File: rtl/lic_pkg.sv
package lic_pkg;
  // access size codes on the bus
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } lic_size_e;

  localparam int REG_W     = 16;
  localparam int HIDX_VEC  = 0;   // halfword index of vector register
  localparam int HIDX_MASK = 1;   // halfword index of enable mask

  // fixed line assignment, lower index wins
  localparam int LINE_PARALLEL = 0;
  localparam int LINE_FLOPPY   = 1;
  localparam int LINE_SOUND    = 2;
  localparam int LINE_VIDEO    = 3;
  localparam int LINE_NETWORK  = 4;
  localparam int LINE_SCSI     = 5;
  localparam int LINE_KEYBOARD = 6;
  localparam int LINE_MOUSE    = 7;
  localparam int LINE_SERIAL0  = 8;
  localparam int LINE_SERIAL1  = 9;
endpackage

// File: rtl/lic_rst_sync.sv
module lic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/lic_req_sample.sv
module lic_req_sample #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] src_o
);
  logic [NUM_LINES-1:0] src_d, src_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb src_d[i] = req_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[i] <= 1'b0;
      else        src_q[i] <= src_d[i];
    end
  end

  assign src_o = src_q;

  // armed one cycle after reset so $past never reaches into reset
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R1
  src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (src_q == $past(req_i)));
endmodule

// File: rtl/lic_prio_enc.sv
module lic_prio_enc #(
  parameter int NUM_LINES = 16
) (
  input  logic [NUM_LINES-1:0]    pending_i,
  output logic [NUM_LINES-1:0]    grant_o,
  output logic                    any_o,
  output logic [lic_pkg::REG_W-1:0] vec_o
);
  import lic_pkg::*;

  logic [NUM_LINES:0] lower;  // lower[i]: some line below i pending

  assign lower[0] = 1'b0;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chain
    assign lower[i+1]  = lower[i] | pending_i[i];
    assign grant_o[i]  = pending_i[i] & ~lower[i];
  end

  assign any_o = lower[NUM_LINES];

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (grant_o[i]) vec_o = vec_o | REG_W'((i + 1) * 4);
    end
  end
endmodule

// File: rtl/lic_regif.sv
module lic_regif #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_i,
  input  logic                    wr_i,
  input  logic [1:0]              size_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  input  logic [lic_pkg::REG_W-1:0] vec_i,
  output logic [31:0]             rdata_o,
  output logic [lic_pkg::REG_W-1:0] mask_o
);
  import lic_pkg::*;

  localparam logic [31:0]      LM32      = (32'd1 << NUM_LINES) - 32'd1;
  localparam logic [REG_W-1:0] LINE_MASK = LM32[REG_W-1:0];

  logic [REG_W-1:0]  mask_d, mask_q;
  logic              mask_we;
  logic [1:0]        be;
  logic [REG_W-1:0]  wd;
  logic [ADDR_W-1:0] hidx, hnext;

  function automatic logic [REG_W-1:0] half_read(
    input logic [ADDR_W-1:0] h,
    input logic [REG_W-1:0]  vec,
    input logic [REG_W-1:0]  mask);
    if (h == ADDR_W'(HIDX_VEC))       return vec;
    else if (h == ADDR_W'(HIDX_MASK)) return mask;
    else                              return '0;
  endfunction

  // halfword indices, computed wide enough not to wrap
  assign hidx  = {1'b0, addr_i[ADDR_W-1:1]};
  assign hnext = hidx + ADDR_W'(1);

  // write decode onto the mask halfword with byte enables
  always_comb begin
    be = 2'b00;
    wd = '0;
    if (sel_i && wr_i) begin
      case (lic_size_e'(size_i))
        SZ_BYTE: begin
          if (hidx == ADDR_W'(HIDX_MASK)) begin
            be = addr_i[0] ? 2'b10 : 2'b01;
            wd = {wdata_i[7:0], wdata_i[7:0]};
          end
        end
        SZ_HALF: begin
          if (hidx == ADDR_W'(HIDX_MASK)) begin
            be = 2'b11;
            wd = wdata_i[15:0];
          end
        end
        default: begin
          if (hidx == ADDR_W'(HIDX_MASK)) begin
            be = 2'b11;
            wd = wdata_i[15:0];
          end else if (hnext == ADDR_W'(HIDX_MASK)) begin
            be = 2'b11;
            wd = wdata_i[31:16];
          end
        end
      endcase
    end
  end

  // next-state for the mask
  always_comb begin
    mask_we = |be;
    mask_d  = mask_q;
    if (be[0]) mask_d[7:0]  = wd[7:0];
    if (be[1]) mask_d[15:8] = wd[15:8];
    mask_d = mask_d & LINE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // read mux
  always_comb begin
    logic [REG_W-1:0] lo;
    rdata_o = '0;
    lo = half_read(hidx, vec_i, mask_q);
    if (sel_i && !wr_i) begin
      case (lic_size_e'(size_i))
        SZ_BYTE: rdata_o[7:0]  = addr_i[0] ? lo[15:8] : lo[7:0];
        SZ_HALF: rdata_o[15:0] = lo;
        default: rdata_o = {half_read(hnext, vec_i, mask_q), lo};
      endcase
    end
  end

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_i && wr_i) |=> $stable(mask_q));

  // R4
  mask_half_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && size_i == 2'b01 && addr_i[ADDR_W-1:1] == (ADDR_W-1)'(HIDX_MASK))
    |=> (mask_q == ($past(wdata_i[15:0]) & LINE_MASK)));

  // R4
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~LINE_MASK) == '0);
endmodule

// File: rtl/local_irq_ctrl.sv
module local_irq_ctrl #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [1:0]           bus_size_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o
);
  import lic_pkg::*;

  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] src;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] grant;
  logic                 any;
  logic [REG_W-1:0]     vec;
  logic [REG_W-1:0]     mask;

  lic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lic_req_sample #(.NUM_LINES(NUM_LINES)) u_sample (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req_i (req_i),
    .src_o (src)
  );

  assign pending = src & mask[NUM_LINES-1:0];

  lic_prio_enc #(.NUM_LINES(NUM_LINES)) u_enc (
    .pending_i (pending),
    .grant_o   (grant),
    .any_o     (any),
    .vec_o     (vec)
  );

  lic_regif #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .size_i  (bus_size_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .vec_i   (vec),
    .rdata_o (bus_rdata_o),
    .mask_o  (mask)
  );

  assign irq_o = any;

  // R2
  irq_vec_agree_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == (vec != '0));

  // R3
  vec_pending_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec != '0) |-> (src[int'(vec[REG_W-1:2]) - 1] && mask[int'(vec[REG_W-1:2]) - 1]));

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq_o && mask == '0));
endmodule

// File: tb/local_irq_ctrl_test.sv
module local_irq_ctrl_test;
  localparam int N  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          sel, wr;
  logic [1:0]    size;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  local_irq_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_size_i(size),
    .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] exp_vec(input logic [N-1:0] r, input logic [15:0] m);
    for (int i = 0; i < N; i++) if (r[i] && m[i]) return 16'((i + 1) * 4);
    return 16'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; size = s; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] s, input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; size = s; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic set_req(input logic [N-1:0] r);
    @(negedge clk);
    req = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    check("R8 irq after reset", {31'b0, irq}, 0);
    bus_read(2'd1, 4'd0, d); check("R8 vector after reset", d, 0);
    bus_read(2'd1, 4'd2, d); check("R8 mask after reset", d, 0);
  endtask

  task automatic t_mask_half;
    logic [31:0] d;
    bus_write(2'd1, 4'd2, 32'hFFFF_A5C3);
    bus_read(2'd1, 4'd2, d); check("R4 mask halfword rw", d, 32'h0000_A5C3);
  endtask

  task automatic t_byte_merge;
    logic [31:0] d;
    bus_write(2'd0, 4'd2, 32'h0000_0011);
    bus_read(2'd1, 4'd2, d); check("R5 low byte merge", d, 32'h0000_A511);
    bus_write(2'd0, 4'd3, 32'h0000_007E);
    bus_read(2'd1, 4'd2, d); check("R5 high byte merge", d, 32'h0000_7E11);
    bus_read(2'd0, 4'd3, d); check("R5 byte read odd", d, 32'h0000_007E);
    bus_read(2'd0, 4'd2, d); check("R5 byte read even", d, 32'h0000_0011);
  endtask

  task automatic t_word_split;
    logic [31:0] d;
    bus_write(2'd2, 4'd0, 32'h1234_BEEF);
    bus_read(2'd1, 4'd2, d); check("R6 word write at 0 loads mask", d, 32'h0000_1234);
    bus_read(2'd2, 4'd0, d); check("R6 word read at 0", d, 32'h1234_0000);
    bus_read(2'd3, 4'd2, d); check("R6 word read at 2", d, 32'h0000_1234);
    bus_write(2'd3, 4'd2, 32'hAAAA_00FF);
    bus_read(2'd1, 4'd2, d); check("R6 word write at 2", d, 32'h0000_00FF);
  endtask

  task automatic t_level;
    logic [31:0] d;
    bus_write(2'd1, 4'd2, 32'h0000_FFFF);
    set_req(16'h0020);
    check("R1 irq follows high line", {31'b0, irq}, 1);
    bus_read(2'd1, 4'd0, d); check("R3 single line vector", d, 32'd24);
    set_req(16'h0000);
    check("R1 irq drops with line", {31'b0, irq}, 0);
    bus_read(2'd1, 4'd0, d); check("R3 vector zero idle", d, 0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    bus_write(2'd1, 4'd2, 32'h0000_0000);
    set_req(16'h0008);
    check("R2 masked line no irq", {31'b0, irq}, 0);
    bus_read(2'd1, 4'd0, d); check("R2 masked line vector", d, 0);
    bus_write(2'd1, 4'd2, 32'h0000_0008);
    check("R2 irq on mask enable", {31'b0, irq}, 1);
    bus_read(2'd1, 4'd0, d); check("R2 vector on mask enable", d, 32'(exp_vec(16'h0008, 16'h0008)));
  endtask

  task automatic t_priority;
    logic [31:0] d;
    bus_write(2'd1, 4'd2, 32'h0000_FFFF);
    set_req(16'h8000);
    bus_read(2'd1, 4'd0, d); check("R3 top line vector", d, 32'd64);
    set_req(16'h8001);
    bus_read(2'd1, 4'd0, d); check("R3 line 0 wins", d, 32'd4);
    bus_write(2'd1, 4'd2, 32'h0000_FFFE);
    bus_read(2'd1, 4'd0, d); check("R3 masked lowest skipped", d, 32'd64);
  endtask

  task automatic t_named;
    logic [31:0] d;
    bus_write(2'd1, 4'd2, 32'h0000_FFFF);
    set_req(16'h0050);  // network + keyboard
    bus_read(2'd1, 4'd0, d); check("R9 network over keyboard", d, 32'd20);
    set_req(16'h0202);  // floppy + serial1
    bus_read(2'd1, 4'd0, d); check("R9 floppy over serial1", d, 32'd8);
    set_req(16'h0300);  // serial0 + serial1
    bus_read(2'd1, 4'd0, d); check("R9 serial0 over serial1", d, 32'd36);
    set_req(16'h0000);
  endtask

  task automatic t_undefined;
    logic [31:0] d;
    bus_write(2'd1, 4'd2, 32'h0000_00F0);
    bus_write(2'd1, 4'd4, 32'h0000_FFFF);
    bus_write(2'd0, 4'd9, 32'h0000_00FF);
    bus_write(2'd2, 4'd6, 32'hFFFF_FFFF);
    bus_write(2'd1, 4'd0, 32'h0000_FFFF);
    bus_read(2'd1, 4'd2, d); check("R7 mask untouched", d, 32'h0000_00F0);
    bus_read(2'd1, 4'd4, d); check("R7 undefined read", d, 0);
    bus_read(2'd2, 4'd6, d); check("R7 undefined word read", d, 0);
    bus_read(2'd2, 4'd14, d); check("R7 top word read", d, 0);
  endtask

  task automatic t_reset_again;
    logic [31:0] d;
    set_req(16'h0010);
    check("R8 irq before reset", {31'b0, irq}, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R8 irq in reset", {31'b0, irq}, 0);
    req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(2'd1, 4'd2, d); check("R8 mask cleared", d, 0);
    check("R8 irq low after reset", {31'b0, irq}, 0);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; sel = 1'b0; wr = 1'b0;
    size = 2'd0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_mask_half();
    t_byte_merge();
    t_word_split();
    t_level();
    t_masked();
    t_priority();
    t_named();
    t_undefined();
    t_reset_again();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule